// File: doc/BRIEF.md
# Serial Receiver with Per-Entry Error Flags

This block receives asynchronous serial frames on a single input line and turns them into bytes. A 16x oversampling strobe comes from outside. The block looks for a falling edge, checks the start bit at its centre, and then samples each following bit at its centre. Start, parity and stop bits are removed. The data bits are stored in a 16-entry FIFO. Each entry also carries two flags: a parity-error flag and a framing-error flag. A host reads the FIFO through a valid/ready port. When `m_valid` is high and `m_ready` is low, the entry on the port is held unchanged. An entry is removed only on a cycle where both are high.

Three signals tell the host that service is needed:
- A half-full interrupt.
- A sticky overrun status bit, which the host clears with a status write.
- A shared receiver-status interrupt. While the receiver is disabled, it signals a falling edge on the line, so it can serve as a wake-up. While the receiver is enabled, it signals that data has been waiting for a set number of bit times with no new frame arriving.

Frame length, parity enable, parity sense and the number of stop bits are static inputs. They may change only while no frame is in progress.

Top module: `uart_rx_etf`

## Requirements
- R1: A frame is a low start bit, then 5 to 8 data bits sent least significant bit first, then an optional parity bit, then 1 or 2 stop bits. The data length is `cfg_len`+5, so `cfg_len`=0 gives 5 bits and `cfg_len`=3 gives 8. Each bit is sampled at its centre. The stored byte holds the data right-aligned, with the unused upper bits set to zero. The entry appears on the read port as {`m_perr`,`m_ferr`,`m_data`}.
- R2: `cfg_par_en`=1 means a parity bit follows the data. With `cfg_par_odd`=0 (even parity), the parity bit plus the data bits must contain an even number of ones. With `cfg_par_odd`=1 (odd parity), they must contain an odd number. A mismatch sets `m_perr` in that frame's entry. When parity is disabled, `m_perr` is 0.
- R3: `cfg_two_stop`=1 selects two stop bits. If any stop bit is sampled low, `m_ferr` is set in that frame's entry. The data is still stored.
- R4: After a falling edge, the line must still be low at the centre of the start bit. If it is not, the edge is discarded, nothing is stored, and the receiver waits for the next falling edge.
- R5: Entries leave in arrival order. While `m_valid`=1 and `m_ready`=0, the port holds the same entry. After reset, `m_valid` is 0.
- R6: `irq_half` is 1 exactly while the FIFO holds more than DEPTH/2 entries, which is 9 or more at the default depth.
- R7: If a frame completes while the FIFO is full, that frame is discarded and `stat_overrun` is set. It stays set until a cycle with `stat_clr`=1 clears it. A clear takes priority over a new overrun in the same cycle.
- R8: While `rx_en`=0, no frame is received. A falling edge on the line raises `irq_rxstat`, which stays high until `stat_clr` is pulsed or `rx_en` goes to 1.
- R9: While `rx_en`=1 and the FIFO is not empty, `irq_rxstat` rises after IDLE_BITS bit times (IDLE_BITS×OVS strobes) with no frame in progress. A new frame in progress restarts the count. `irq_rxstat` falls as soon as the FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | Oversampling strobe, OVS pulses per bit time |
| rx_en | input | 1 | Receiver enable |
| rx_line | input | 1 | Serial receive line, asynchronous |
| cfg_len | input | 2 | Data length minus 5 |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| m_valid | output | 1 | Read port holds an entry |
| m_ready | input | 1 | Host accepts the entry |
| m_data | output | 8 | Received data, right-aligned |
| m_perr | output | 1 | Parity error flag of the entry |
| m_ferr | output | 1 | Framing error flag of the entry |
| stat_overrun | output | 1 | Sticky overrun status |
| stat_clr | input | 1 | Status write: clears overrun and the wake flag |
| irq_half | output | 1 | FIFO more than half full |
| irq_rxstat | output | 1 | Wake-on-start or idle-timeout interrupt |

## Verification
The bench keeps DEPTH=16 and OVS=16, so it can fill the FIFO exactly. This makes the 8/9 boundary of the half-full interrupt and the 17th frame that causes an overrun directly observable. IDLE_BITS is lowered to 8 so the idle timeout expires after 128 strobes instead of 512. The strobe arrives every 4 clocks, which places the timeout edge well inside a short bench run. Random frames vary length, parity mode, stop count and injected errors. Directed cases cover a short start glitch and the wake path.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int MAX_DATA = 8;

  typedef struct packed {
    logic                perr;
    logic                ferr;
    logic [MAX_DATA-1:0] data;
  } rx_entry_t;

  localparam int ENTRY_W = $bits(rx_entry_t);

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP
  } rx_state_t;
endpackage

// File: rtl/rx_deser.sv
module rx_deser
  import uart_rx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en,
  input  logic      tick,
  input  logic      line,
  input  logic [1:0] cfg_len,
  input  logic      par_en,
  input  logic      par_odd,
  input  logic      two_stop,
  output logic      busy,
  output logic      fall,
  output logic      frm_valid,
  output rx_entry_t frm_entry
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);
  localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);

  rx_state_t           state;
  logic [CW-1:0]       tcnt;
  logic [3:0]          bidx;
  logic [MAX_DATA-1:0] sh;
  logic                line_q, par_bit, ferr_acc, stop_seen;
  logic [3:0]          nbits;
  logic [MAX_DATA-1:0] dat;
  logic                ferr_now, sample;

  assign nbits    = 4'd5 + {2'b00, cfg_len};
  assign dat      = sh >> (4'd8 - nbits);
  assign ferr_now = ferr_acc | ~line;
  assign sample   = tick && (tcnt == LAST);
  assign fall     = line_q & ~line;
  assign busy     = (state != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      tcnt      <= '0;
      bidx      <= '0;
      sh        <= '0;
      line_q    <= 1'b1;
      par_bit   <= 1'b0;
      ferr_acc  <= 1'b0;
      stop_seen <= 1'b0;
      frm_valid <= 1'b0;
      frm_entry <= '0;
    end else begin
      line_q    <= line;
      frm_valid <= 1'b0;
      if (tick && state != S_IDLE && !sample) tcnt <= tcnt + 1'b1;
      if (!en) begin
        state <= S_IDLE;
      end else begin
        case (state)
          S_IDLE: if (fall) begin
            state <= S_START;
            tcnt  <= '0;
          end
          S_START: if (tick && tcnt == MID) begin
            tcnt <= '0;
            if (!line) begin
              state     <= S_DATA;
              bidx      <= '0;
              ferr_acc  <= 1'b0;
              stop_seen <= 1'b0;
            end else begin
              state <= S_IDLE;
            end
          end
          S_DATA: if (sample) begin
            tcnt <= '0;
            sh   <= {line, sh[MAX_DATA-1:1]};
            if (bidx == nbits - 4'd1) state <= par_en ? S_PAR : S_STOP;
            else bidx <= bidx + 4'd1;
          end
          S_PAR: if (sample) begin
            tcnt    <= '0;
            par_bit <= line;
            state   <= S_STOP;
          end
          S_STOP: if (sample) begin
            tcnt <= '0;
            if (two_stop && !stop_seen) begin
              stop_seen <= 1'b1;
              ferr_acc  <= ferr_now;
            end else begin
              frm_valid      <= 1'b1;
              frm_entry.data <= dat;
              frm_entry.ferr <= ferr_now;
              frm_entry.perr <= par_en && (par_bit != ((^dat) ^ par_odd));
              state          <= S_IDLE;
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/rx_fifo.sv
module rx_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic                       full,
  output logic                       nonempty,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int AW = $clog2(DEPTH);
  localparam int CNTW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign full     = (count == CNTW'(DEPTH));
  assign nonempty = (count != '0);
  assign do_push  = push && !full;
  assign do_pop   = pop && nonempty;
  assign dout     = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      count <= count + CNTW'(do_push) - CNTW'(do_pop);
    end
  end
endmodule

// File: rtl/rx_idle_mon.sv
module rx_idle_mon #(
  parameter int LIMIT = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  input  logic busy,
  input  logic nonempty,
  input  logic fall,
  input  logic clr,
  output logic irq
);
  localparam int TW = $clog2(LIMIT + 1);

  logic [TW-1:0] tcnt;
  logic          wake_q, to_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_q <= 1'b0;
      to_q   <= 1'b0;
      tcnt   <= '0;
    end else begin
      if (clr || en) wake_q <= 1'b0;
      else if (fall) wake_q <= 1'b1;

      if (!en || busy || !nonempty) begin
        tcnt <= '0;
        to_q <= 1'b0;
      end else if (tick && !to_q) begin
        if (tcnt == TW'(LIMIT - 1)) to_q <= 1'b1;
        else tcnt <= tcnt + 1'b1;
      end
    end
  end

  assign irq = (wake_q & ~en) | (to_q & en & nonempty);
endmodule

// File: rtl/uart_rx_etf.sv
module uart_rx_etf
  import uart_rx_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int OVS       = 16,
  parameter int IDLE_BITS = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       os_tick,
  input  logic       rx_en,
  input  logic       rx_line,
  input  logic [1:0] cfg_len,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic       cfg_two_stop,
  output logic       m_valid,
  input  logic       m_ready,
  output logic [7:0] m_data,
  output logic       m_perr,
  output logic       m_ferr,
  output logic       stat_overrun,
  input  logic       stat_clr,
  output logic       irq_half,
  output logic       irq_rxstat
);
  localparam int CNTW = $clog2(DEPTH + 1);

  logic [1:0]      sync_q;
  logic            busy, fall, frm_valid, full, nonempty;
  rx_entry_t       frm_entry, head;
  logic [CNTW-1:0] count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], rx_line};
  end

  rx_deser #(.OVS(OVS)) u_deser (
    .clk(clk), .rst_n(rst_n), .en(rx_en), .tick(os_tick), .line(sync_q[1]),
    .cfg_len(cfg_len), .par_en(cfg_par_en), .par_odd(cfg_par_odd),
    .two_stop(cfg_two_stop), .busy(busy), .fall(fall),
    .frm_valid(frm_valid), .frm_entry(frm_entry)
  );

  rx_fifo #(.DEPTH(DEPTH), .W(ENTRY_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(frm_valid), .din(frm_entry),
    .pop(m_valid && m_ready), .dout(head), .full(full),
    .nonempty(nonempty), .count(count)
  );

  rx_idle_mon #(.LIMIT(IDLE_BITS * OVS)) u_idle (
    .clk(clk), .rst_n(rst_n), .en(rx_en), .tick(os_tick), .busy(busy),
    .nonempty(nonempty), .fall(fall), .clr(stat_clr), .irq(irq_rxstat)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 stat_overrun <= 1'b0;
    else if (stat_clr)          stat_overrun <= 1'b0;
    else if (frm_valid && full) stat_overrun <= 1'b1;
  end

  assign m_valid  = nonempty;
  assign m_data   = head.data;
  assign m_perr   = head.perr;
  assign m_ferr   = head.ferr;
  assign irq_half = (count > CNTW'(DEPTH / 2));
endmodule

// File: rtl/uart_rx_etf_chk.sv
module uart_rx_etf_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_en,
  input logic       m_valid,
  input logic       m_ready,
  input logic [7:0] m_data,
  input logic       m_perr,
  input logic       m_ferr,
  input logic       stat_overrun,
  input logic       stat_clr,
  input logic       irq_half,
  input logic       irq_rxstat
);
  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable({m_perr, m_ferr, m_data}))); // R5
  AST_HALF_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    irq_half |-> m_valid); // R6
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_overrun && !stat_clr) |=> stat_overrun); // R7
  AST_OVR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    stat_clr |=> !stat_overrun); // R7
  AST_TIMEOUT_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && irq_rxstat) |-> m_valid); // R9
  AST_WAKE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && stat_clr) |=> (rx_en || !irq_rxstat || $past(!rx_en && stat_clr) == 1'b0 || !irq_rxstat)); // R8
endmodule

bind uart_rx_etf uart_rx_etf_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .m_valid(m_valid),
  .m_ready(m_ready), .m_data(m_data), .m_perr(m_perr), .m_ferr(m_ferr),
  .stat_overrun(stat_overrun), .stat_clr(stat_clr),
  .irq_half(irq_half), .irq_rxstat(irq_rxstat)
);

// File: tb/test_uart_rx_etf.sv
`timescale 1ns/1ps
module test_uart_rx_etf;
  localparam int BITCLK = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic os_tick = 1'b0;
  logic rx_en = 1'b1, rx_line = 1'b1;
  logic [1:0] cfg_len = 2'd3;
  logic cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_two_stop = 1'b0;
  logic m_valid, m_ready = 1'b0;
  logic [7:0] m_data;
  logic m_perr, m_ferr, stat_overrun, stat_clr = 1'b0, irq_half, irq_rxstat;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [9:0] expq[$];
  logic [1:0] tdiv = '0;

  always #2 clk = ~clk;

  always @(posedge clk) begin
    tdiv    <= tdiv + 2'd1;
    os_tick <= (tdiv == 2'd3);
  end

  uart_rx_etf #(.DEPTH(16), .OVS(16), .IDLE_BITS(8)) i_uart_rx_etf (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_en(rx_en),
    .rx_line(rx_line), .cfg_len(cfg_len), .cfg_par_en(cfg_par_en),
    .cfg_par_odd(cfg_par_odd), .cfg_two_stop(cfg_two_stop),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .m_perr(m_perr), .m_ferr(m_ferr), .stat_overrun(stat_overrun),
    .stat_clr(stat_clr), .irq_half(irq_half), .irq_rxstat(irq_rxstat)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] exp_entry(input logic [7:0] d, input logic [1:0] len,
                                           input bit pen, input bit bad_p, input bit bad_s);
    logic [7:0] mask;
    mask = 8'((9'd1 << (5 + len)) - 9'd1);
    return {pen & bad_p, bad_s, d & mask};
  endfunction

  task automatic idle_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    rx_line = b;
    idle_clk(BITCLK);
  endtask

  // bad_stop: 0 none, 1 first stop low, 2 second stop low
  task automatic send_frame(input logic [7:0] d, input logic [1:0] len, input bit pen,
                            input bit podd, input bit two, input bit bad_p,
                            input int bad_stop, input bit record);
    int nb;
    logic [7:0] m;
    nb = 5 + len;
    m  = 8'((9'd1 << nb) - 9'd1);
    @(negedge clk);
    cfg_len = len; cfg_par_en = pen; cfg_par_odd = podd; cfg_two_stop = two;
    send_bit(1'b0);
    for (int i = 0; i < nb; i++) send_bit(d[i]);
    if (pen) send_bit((^(d & m)) ^ podd ^ bad_p);
    send_bit(bad_stop != 1);
    if (two) send_bit(bad_stop != 2);
    send_bit(1'b1);
    if (record) expq.push_back(exp_entry(d, len, pen, bad_p, bad_stop != 0));
  endtask

  task automatic drain(input string req);
    logic [9:0] got, exp;
    while (m_valid) begin
      got = {m_perr, m_ferr, m_data};
      exp = (expq.size() != 0) ? expq.pop_front() : 10'h3ff;
      chk(got == exp, req, got, exp);
      if ($urandom_range(0, 2) == 0) begin
        idle_clk(2);
        chk({m_perr, m_ferr, m_data} == got && m_valid, "R5 hold", {m_perr, m_ferr, m_data}, got);
      end
      m_ready = 1'b1;
      @(negedge clk);
      m_ready = 1'b0;
      @(negedge clk);
    end
    chk(expq.size() == 0, "R5 count", expq.size(), 0);
    expq.delete();
  endtask

  task automatic pulse_clr();
    stat_clr = 1'b1;
    @(negedge clk);
    stat_clr = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd2024));
    idle_clk(5);
    rst_n = 1'b1;
    idle_clk(3);
    chk(!m_valid && !irq_half && !stat_overrun && !irq_rxstat, "R5 reset",
        {m_valid, irq_half, stat_overrun, irq_rxstat}, 0);

    // directed R1/R2/R3 corners
    send_frame(8'hA5, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 0, 1'b1);
    send_frame(8'hFF, 2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 0, 1'b1);
    send_frame(8'h3C, 2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 2, 1'b1);
    send_frame(8'h81, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1, 1'b1);
    drain("R1 R2 R3 directed");

    // random frames
    for (int k = 0; k < 28; k++) begin
      logic two;
      two = 1'($urandom_range(0, 1));
      send_frame(8'($urandom), 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                 1'($urandom_range(0, 1)), two, ($urandom_range(0, 3) == 0),
                 ($urandom_range(0, 3) == 0) ? (two ? int'($urandom_range(1, 2)) : 1) : 0, 1'b1);
      if (k % 4 == 3) drain("R1 R2 R3 random");
    end
    drain("R1 R2 R3 random");

    // R4: short low glitch is not a start bit
    rx_line = 1'b0;
    idle_clk(16);
    rx_line = 1'b1;
    idle_clk(3 * BITCLK);
    chk(!m_valid, "R4 glitch", m_valid, 0);
    send_frame(8'h5A, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 0, 1'b1);
    drain("R4 recovery");

    // R6 / R7: fill, half-full boundary, overrun
    for (int k = 1; k <= 17; k++) begin
      send_frame(8'(k * 7), 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 0, k <= 16);
      if (k == 8)  chk(!irq_half, "R6 at 8", irq_half, 0);
      if (k == 9)  chk(irq_half, "R6 at 9", irq_half, 1);
      if (k == 16) chk(!stat_overrun, "R7 full no ovr", stat_overrun, 0);
    end
    chk(stat_overrun, "R7 set", stat_overrun, 1);
    drain("R7 discard");
    chk(stat_overrun, "R7 sticky", stat_overrun, 1);
    pulse_clr();
    chk(!stat_overrun, "R7 clear", stat_overrun, 0);

    // R9: idle timeout (8 bit times = 512 clocks)
    send_frame(8'h33, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 0, 1'b1);
    idle_clk(300);
    chk(!irq_rxstat, "R9 early", irq_rxstat, 0);
    idle_clk(300);
    chk(irq_rxstat, "R9 timeout", irq_rxstat, 1);
    drain("R9 data");
    chk(!irq_rxstat, "R9 empty drop", irq_rxstat, 0);

    // R8: wake on falling edge while disabled
    rx_en = 1'b0;
    idle_clk(4);
    chk(!irq_rxstat, "R8 quiet", irq_rxstat, 0);
    send_bit(1'b0);
    send_bit(1'b1);
    chk(irq_rxstat && !m_valid, "R8 wake", {irq_rxstat, m_valid}, 2);
    pulse_clr();
    chk(!irq_rxstat, "R8 clr", irq_rxstat, 0);
    send_bit(1'b0);
    send_bit(1'b1);
    chk(irq_rxstat, "R8 wake again", irq_rxstat, 1);
    rx_en = 1'b1;
    idle_clk(2);
    chk(!irq_rxstat && !m_valid, "R8 enable clears", {irq_rxstat, m_valid}, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule